// File: doc/BRIEF.md
# Terminal Address Capture Unit

This block produces the 5-bit terminal address and its parity bit for a remote terminal on a serial command/response bus. The value can come from five address pins and a parity pin, or from the low six bits of the host data bus. A source-select input chooses between the two.

An asynchronous latch-control pin is brought into the system clock domain through a two-flop synchronizer, and it sets how the value is captured. While the pin is low, the internal value follows the pins. When the pin rises, the pin value is frozen. While the pin stays high, the value changes only through a host write sequence: set an enhanced-mode bit, set a latch-enable bit, then write the address register.

A registered flag reports whether the captured six bits hold an odd number of ones. The terminal may answer non-broadcast commands only when this flag is set. Host writes are plain single-cycle strobes with no back-pressure. Every write is accepted in the cycle it is presented, so the write port has no ready signal. The control and status pins are plain levels.

Top module: `rt_addr_unit`

## Requirements
- R1: During reset and right after it, `term_addr`, `term_par` and `addr_ok` are all 0, and the enhanced-mode and latch-enable bits are cleared.
- R2: Once the synchronized latch-control level is low, every clock loads `{pin_addr, pin_par}` into the captured value, so a pin change appears on `term_addr`/`term_par` one clock later.
- R3: `latch_ctl` passes through two synchronizer flops. On the clock where the synchronized level first reads 1, the pins are captured. Later pin changes do not reach the outputs while the level stays high.
- R4: Register select encoding: 0 is the mode register (bit 15 is enhanced mode), 1 is the latch register (bit 3 is latch enable), 2 is the address register, and 3 is unused. With the level high, a write to select 2 loads a new value only if both bits are 1. Otherwise, and for any write to select 3, the outputs do not change.
- R5: When `src_sel` is 1, a qualifying address-register write loads `wr_data[5:1]` into `term_addr[4:0]` and `wr_data[0]` into `term_par`.
- R6: When `src_sel` is 0, a qualifying address-register write loads the pin values, and `wr_data` has no effect on the result.
- R7: `addr_ok` is 1 exactly when the captured five address bits and the parity bit together hold an odd number of ones. It follows a change of the captured value by one clock.
- R8: If `latch_ctl` is high through reset, the outputs stay 0 after reset until the first qualifying address-register write, whatever the pins carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_addr | input | 5 | Address pins |
| pin_par | input | 1 | Parity pin |
| latch_ctl | input | 1 | Asynchronous latch-control pin |
| src_sel | input | 1 | 0: pins, 1: host data for register loads |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 16 | Host write data |
| term_addr | output | 5 | Captured terminal address |
| term_par | output | 1 | Captured parity bit |
| addr_ok | output | 1 | Odd-parity valid flag for non-broadcast response |

## Verification
A wrong enable bit or a broken capture path shows on `term_addr` in the clock after the address-register write that should have loaded it, or after the write that should have been refused. A synchronizer fault shifts the capture instant: the pin value sampled on the edge where the level first reads high is then missing. A fault in the parity flag appears one clock after the captured value changes. Every check samples at those exact points, both for directed corner cases and for random write sequences.

// File: rtl/rt_addr_pkg.sv
package rt_addr_pkg;
  localparam int ADDR_W  = 5;
  localparam int TAG_W   = ADDR_W + 1;
  localparam int DATA_W  = 16;
  localparam int ENH_BIT = 15;
  localparam int LEN_BIT = 3;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_ADDR  = 2'd2,
    SEL_SPARE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/rt_lat_sync.sv
module rt_lat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;   // assume high: no false edge on reset exit
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/rt_cfg_bits.sv
module rt_cfg_bits
  import rt_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enh_q,
  output logic              len_q,
  output logic              load
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enh_q <= 1'b0;
      len_q <= 1'b0;
    end else if (wr_en) begin
      if (sel == SEL_MODE)  enh_q <= wr_data[ENH_BIT];
      if (sel == SEL_LATCH) len_q <= wr_data[LEN_BIT];
    end
  end

  assign load = wr_en && (sel == SEL_ADDR) && enh_q && len_q;

  // R4
  enh_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (enh_q == $past(wr_data[ENH_BIT])));
  // R4
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd1) |=> $stable(len_q));
endmodule

// File: rtl/rt_addr_hold.sv
module rt_addr_hold
  import rt_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             rise,
  input  logic             load,
  input  logic             src_sel,
  input  logic [TAG_W-1:0] pin_word,
  input  logic [TAG_W-1:0] host_word,
  output logic [TAG_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                word_q <= '0;
    else if (!level || rise)   word_q <= pin_word;
    else if (load)             word_q <= src_sel ? host_word : pin_word;
  end

  // R2
  transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !level |=> (word_q == $past(pin_word)));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level && !rise && !load) |=> $stable(word_q));
endmodule

// File: rtl/rt_par_flag.sv
module rt_par_flag
  import rt_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] word,
  output logic             ok_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ^word;
  end

  // R7
  ok_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(word) |=> $stable(ok_q));
endmodule

// File: rtl/rt_addr_unit.sv
module rt_addr_unit
  import rt_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic              pin_par,
  input  logic              latch_ctl,
  input  logic              src_sel,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] term_addr,
  output logic              term_par,
  output logic              addr_ok
);
  logic level, rise, enh_q, len_q, load;
  logic [TAG_W-1:0] word_q;

  rt_lat_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(latch_ctl), .level(level), .rise(rise));

  rt_cfg_bits u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .enh_q(enh_q), .len_q(len_q), .load(load));

  rt_addr_hold u_hold (
    .clk(clk), .rst_n(rst_n), .level(level), .rise(rise), .load(load),
    .src_sel(src_sel), .pin_word({pin_addr, pin_par}),
    .host_word(wr_data[TAG_W-1:0]), .word_q(word_q));

  rt_par_flag u_par (
    .clk(clk), .rst_n(rst_n), .word(word_q), .ok_q(addr_ok));

  assign term_addr = word_q[TAG_W-1:1];
  assign term_par  = word_q[0];

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (term_addr == '0 && !term_par && !addr_ok));
endmodule

// File: tb/rt_addr_unit_bench.sv
module rt_addr_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] pin_addr = '0;
  logic pin_par = 1'b0, latch_ctl = 1'b0, src_sel = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [4:0] term_addr;
  logic term_par, addr_ok;
  int n_cmp = 0, n_bad = 0;
  logic [5:0] exp_w;
  bit m_enh, m_len;

  always #2 clk = ~clk;

  rt_addr_unit u_rt_addr_unit (
    .clk(clk), .rst_n(rst_n), .pin_addr(pin_addr), .pin_par(pin_par),
    .latch_ctl(latch_ctl), .src_sel(src_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .term_addr(term_addr), .term_par(term_par), .addr_ok(addr_ok));

  function automatic logic odd6(input logic [5:0] w);
    return ^w;
  endfunction

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [5:0] w);
    cmp(req, int'({term_addr, term_par}), int'(w));
  endtask

  task automatic write(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (s == 2'd0) m_enh = d[15];
    if (s == 2'd1) m_len = d[3];
    if (s == 2'd2 && m_enh && m_len) exp_w = src_sel ? d[5:0] : {pin_addr, pin_par};
  endtask

  task automatic do_reset(input logic lat);
    rst_n = 1'b0; latch_ctl = lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_enh = 0; m_len = 0; exp_w = '0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    {pin_addr, pin_par} = 6'h2b;
    do_reset(1'b0);
    chk_word("R1", 6'h00); cmp("R1", int'(addr_ok), 0);
    repeat (4) @(negedge clk);

    // R2 / R7: transparent follow with random pins
    for (int i = 0; i < 24; i++) begin
      logic [5:0] w;
      w = 6'($urandom);
      {pin_addr, pin_par} = w;
      @(negedge clk);
      chk_word("R2", w);
      @(negedge clk);
      cmp("R7", int'(addr_ok), int'(odd6(w)));
    end

    // R3: capture on the clock where the synchronized level first reads 1
    {pin_addr, pin_par} = 6'h15;
    latch_ctl = 1'b1;
    @(negedge clk); @(negedge clk);
    {pin_addr, pin_par} = 6'h2e;      // sampled by the rising-edge capture
    @(negedge clk);
    {pin_addr, pin_par} = 6'h09;
    repeat (3) @(negedge clk);
    chk_word("R3", 6'h2e);
    exp_w = 6'h2e;

    // R4: refused writes
    src_sel = 1'b1;
    write(2'd2, 16'h003f); chk_word("R4", exp_w);
    write(2'd0, 16'h8000); write(2'd2, 16'h0011); chk_word("R4", exp_w);
    write(2'd3, 16'hffff); write(2'd2, 16'h0011); chk_word("R4", exp_w);
    // R5: host-sourced load
    write(2'd1, 16'h0008); write(2'd2, 16'hff25);
    chk_word("R5", 6'h25);
    @(negedge clk); cmp("R7", int'(addr_ok), int'(odd6(6'h25)));
    // R6: pin-sourced load ignores data
    src_sel = 1'b0; {pin_addr, pin_par} = 6'h1c;
    write(2'd2, 16'h0033); chk_word("R6", 6'h1c);
    write(2'd0, 16'h0000); {pin_addr, pin_par} = 6'h07;
    write(2'd2, 16'h0000); chk_word("R4", 6'h1c);

    // random host sequences with latch held high
    for (int i = 0; i < 60; i++) begin
      logic [1:0] s;
      logic [15:0] d;
      s = 2'($urandom); d = 16'($urandom);
      src_sel = 1'($urandom);
      {pin_addr, pin_par} = 6'($urandom);
      write(s, d);
      chk_word(src_sel ? "R5" : "R6", exp_w);
      @(negedge clk);
      cmp("R7", int'(addr_ok), int'(odd6(exp_w)));
    end

    // R8: latch high through reset
    {pin_addr, pin_par} = 6'h3f;
    do_reset(1'b1);
    chk_word("R1", 6'h00);
    repeat (6) @(negedge clk);
    chk_word("R8", 6'h00);
    write(2'd2, 16'h0001); chk_word("R8", 6'h00);
    src_sel = 1'b1;
    write(2'd0, 16'h8000); write(2'd1, 16'h0008); write(2'd2, 16'h0013);
    chk_word("R8", 6'h13);
    @(negedge clk); cmp("R7", int'(addr_ok), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule